// File: doc/BRIEF.md
# Compare-and-skip execution unit

This unit carries out a compare-and-skip instruction. A single start strobe hands it the accumulator, a 16-bit memory operand that has already been fetched, and the word part of the program counter. The unit compares the two values as signed two's-complement numbers. One cycle later it returns the new program counter word, fresh condition codes, a cleared link bit and a one-cycle done pulse.

The result of the compare sets how far the program counter moves. If the accumulator is greater, the counter stays where it is and execution falls through to the next instruction word. If the two values are equal, the counter moves one word and skips one word. If the accumulator is smaller, the counter moves two words and skips two words. The caller decodes the instruction and fetches the operand before it raises start. It takes the new counter value when done is high.

Top module: `cmpskip_unit`

## Requirements
- R1: When start is high and acc_i equals opnd_i, the next cycle shows pc_o = pc_i + 1, cc_eq_o = 1 and cc_lt_o = 0.
- R2: When start is high and acc_i is less than opnd_i as a signed 16-bit value, the next cycle shows pc_o = pc_i + 2, cc_lt_o = 1 and cc_eq_o = 0.
- R3: When start is high and acc_i is greater than opnd_i as a signed value, the next cycle shows pc_o = pc_i and both condition-code outputs at 0.
- R4: Every execution computes both condition codes afresh. A code set by an earlier execution never carries into a later one, and the two codes are never 1 at the same time.
- R5: link_o is 0 after reset and 0 after every execution.
- R6: The program counter adds in 16 bits and wraps. 0xFFFF + 1 gives 0x0000, and 0xFFFF + 2 gives 0x0001.
- R7: done_o is high for exactly the one cycle after each start. While start is low, pc_o, cc_eq_o, cc_lt_o and link_o hold their values.
- R8: The compare is signed. 0x7FFF against 0x8000 is greater (no skip), and 0x8000 against 0x7FFF is less (skip two).
- R9: After reset, pc_o is 0x0000 and cc_eq_o, cc_lt_o, link_o and done_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| start_i | input | 1 | Starts one execution using the current inputs |
| acc_i | input | 16 | Accumulator value |
| opnd_i | input | 16 | Memory operand |
| pc_i | input | 16 | Current program counter word part |
| pc_o | output | 16 | Program counter after the skip |
| cc_eq_o | output | 1 | Equal condition code |
| cc_lt_o | output | 1 | Less-than condition code |
| link_o | output | 1 | Link bit (always cleared) |
| done_o | output | 1 | One-cycle pulse, the cycle after start |

## Verification
The assertions check on every cycle that each of the three compare outcomes produces the right counter step and code pair, that the two codes are never set together, that done follows start by exactly one cycle, and that the outputs hold between executions. The bench scenarios cover the rest. They show that the compare is signed at the 0x7FFF/0x8000 boundary, that the counter wraps at 0xFFFF, that codes from one execution do not leak into the next, and the exact reset values.

// File: rtl/cmpskip_pkg.sv
package cmpskip_pkg;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_EQ = 2'd1,
    CMP_LT = 2'd2
  } cmp_res_e;

  localparam int unsigned STEP_W = 2;

  // number of extra words to move for a compare outcome
  function automatic logic [STEP_W-1:0] skip_words(input cmp_res_e res);
    case (res)
      CMP_EQ:  skip_words = 2'd1;
      CMP_LT:  skip_words = 2'd2;
      default: skip_words = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/cmpskip_rst_sync.sv
module cmpskip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cmpskip_cmp.sv
module cmpskip_cmp
  import cmpskip_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output cmp_res_e     res_o
);
  always_comb begin
    if (a_i == b_i)                    res_o = CMP_EQ;
    else if ($signed(a_i) < $signed(b_i)) res_o = CMP_LT;
    else                               res_o = CMP_GT;
  end
endmodule

// File: rtl/cmpskip_pcadv.sv
module cmpskip_pcadv
  import cmpskip_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] pc_i,
  input  cmp_res_e     res_i,
  output logic [W-1:0] pc_o
);
  localparam int unsigned PAD_W = W - STEP_W;
  logic [W-1:0] step;

  always_comb begin
    step = {{PAD_W{1'b0}}, skip_words(res_i)};
    pc_o = pc_i + step; // modulo 2**W
  end
endmodule

// File: rtl/cmpskip_unit.sv
module cmpskip_unit
  import cmpskip_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic [W-1:0] pc_i,
  output logic [W-1:0] pc_o,
  output logic         cc_eq_o,
  output logic         cc_lt_o,
  output logic         link_o,
  output logic         done_o
);
  logic         rst_sync_n;
  cmp_res_e     res;
  logic [W-1:0] pc_adv;

  logic [W-1:0] pc_d,   pc_q;
  logic         eq_d,   eq_q;
  logic         lt_d,   lt_q;
  logic         link_d, link_q;
  logic         done_d, done_q;
  logic         upd_en;

  cmpskip_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cmpskip_cmp #(.W(W)) u_cmp (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .res_o (res)
  );

  cmpskip_pcadv #(.W(W)) u_pcadv (
    .pc_i  (pc_i),
    .res_i (res),
    .pc_o  (pc_adv)
  );

  // next state: codes are recomputed from scratch on every execution
  always_comb begin
    upd_en = start_i;
    pc_d   = pc_adv;
    eq_d   = (res == CMP_EQ);
    lt_d   = (res == CMP_LT);
    link_d = 1'b0;
    done_d = start_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q   <= '0;
      eq_q   <= 1'b0;
      lt_q   <= 1'b0;
      link_q <= 1'b0;
    end else if (upd_en) begin
      pc_q   <= pc_d;
      eq_q   <= eq_d;
      lt_q   <= lt_d;
      link_q <= link_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  assign pc_o    = pc_q;
  assign cc_eq_o = eq_q;
  assign cc_lt_o = lt_q;
  assign link_o  = link_q;
  assign done_o  = done_q;
endmodule

// File: rtl/cmpskip_unit_chk.sv
module cmpskip_unit_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] opnd_i,
  input logic [W-1:0] pc_i,
  input logic [W-1:0] pc_o,
  input logic         cc_eq_o,
  input logic         cc_lt_o,
  input logic         link_o,
  input logic         done_o
);
  p_eq_skip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && acc_i == opnd_i) |=>
      (pc_o == W'($past(pc_i) + 1) && cc_eq_o && !cc_lt_o));

  p_lt_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && $signed(acc_i) < $signed(opnd_i)) |=>
      (pc_o == W'($past(pc_i) + 2) && cc_lt_o && !cc_eq_o));

  p_gt_noskip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && $signed(acc_i) > $signed(opnd_i)) |=>
      (pc_o == $past(pc_i) && !cc_eq_o && !cc_lt_o));

  p_cc_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cc_eq_o && cc_lt_o));

  p_link_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !link_o);

  p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(pc_o) && $stable(cc_eq_o) && $stable(cc_lt_o) && $stable(link_o)));
endmodule

bind cmpskip_unit cmpskip_unit_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start_i (start_i),
  .acc_i   (acc_i),
  .opnd_i  (opnd_i),
  .pc_i    (pc_i),
  .pc_o    (pc_o),
  .cc_eq_o (cc_eq_o),
  .cc_lt_o (cc_lt_o),
  .link_o  (link_o),
  .done_o  (done_o)
);

// File: tb/cmpskip_unit_tb.sv
`timescale 1ns/1ps
module cmpskip_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] acc_i, opnd_i, pc_i;
  logic [15:0] pc_o;
  logic        cc_eq_o, cc_lt_o, link_o, done_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cmpskip_unit #(.W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .pc_i(pc_i),
    .pc_o(pc_o), .cc_eq_o(cc_eq_o), .cc_lt_o(cc_lt_o),
    .link_o(link_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // run one execution; outputs are sampled on the falling edge after the capturing edge
  task automatic run(input logic [15:0] a, input logic [15:0] b, input logic [15:0] pc);
    @(negedge clk);
    acc_i = a; opnd_i = b; pc_i = pc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic check_exec(input string req, input logic [15:0] a, input logic [15:0] b,
                            input logic [15:0] pc);
    logic [15:0] exp_pc;
    logic        exp_eq, exp_lt;
    exp_eq = (a == b);
    exp_lt = ($signed(a) < $signed(b));
    exp_pc = pc + (exp_eq ? 16'd1 : exp_lt ? 16'd2 : 16'd0);
    run(a, b, pc);
    chk({req, " pc"},   pc_o,    exp_pc);
    chk({req, " eq"},   cc_eq_o, exp_eq);
    chk({req, " lt"},   cc_lt_o, exp_lt);
    chk("R5 link",      link_o,  1'b0);
    chk("R7 done high", done_o,  1'b1);
  endtask

  task automatic t_reset_r9();
    chk("R9 pc",   pc_o,    16'h0000);
    chk("R9 eq",   cc_eq_o, 1'b0);
    chk("R9 lt",   cc_lt_o, 1'b0);
    chk("R9 link", link_o,  1'b0);
    chk("R9 done", done_o,  1'b0);
  endtask

  task automatic t_basic();
    check_exec("R1", 16'h1234, 16'h1234, 16'h0100);
    check_exec("R2", 16'h0005, 16'h0009, 16'h0200);
    check_exec("R3", 16'h0009, 16'h0005, 16'h0300);
    check_exec("R2 neg", 16'hFFF0, 16'h0001, 16'h0400);
  endtask

  task automatic t_fresh_cc_r4();
    check_exec("R4 eq first", 16'h0007, 16'h0007, 16'h0010);
    check_exec("R4 gt after eq", 16'h0008, 16'h0007, 16'h0020);
    check_exec("R4 lt", 16'h0001, 16'h0002, 16'h0030);
    check_exec("R4 gt after lt", 16'h0003, 16'h0002, 16'h0040);
  endtask

  task automatic t_wrap_r6();
    check_exec("R6 +1", 16'h4444, 16'h4444, 16'hFFFF);
    chk("R6 wrap to 0", pc_o, 16'h0000);
    check_exec("R6 +2", 16'h0000, 16'h0001, 16'hFFFF);
    chk("R6 wrap to 1", pc_o, 16'h0001);
  endtask

  task automatic t_signed_r8();
    check_exec("R8 7FFF>8000", 16'h7FFF, 16'h8000, 16'h0500);
    chk("R8 no skip", pc_o, 16'h0500);
    check_exec("R8 8000<7FFF", 16'h8000, 16'h7FFF, 16'h0600);
    chk("R8 skip two", pc_o, 16'h0602);
  endtask

  task automatic t_hold_r7();
    check_exec("R7 setup", 16'h0010, 16'h0020, 16'h0700);
    acc_i = 16'h0020; opnd_i = 16'h0020; pc_i = 16'h1111;
    @(negedge clk);
    chk("R7 done drops", done_o,  1'b0);
    chk("R7 pc held",    pc_o,    16'h0702);
    chk("R7 lt held",    cc_lt_o, 1'b1);
    chk("R7 eq held",    cc_eq_o, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 pc still held", pc_o, 16'h0702);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    acc_i = '0; opnd_i = '0; pc_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_r9();
    t_basic();
    t_fresh_cc_r4();
    t_wrap_r6();
    t_signed_r8();
    t_hold_r7();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule